// File: doc/BRIEF.md
# Multiplexed Bus Slave Address Tracker

This block sits on the device side of a shared address/data bus in which the host sends no address strobe. It watches the bank chip-select to find each access. The first clock edge that sees chip-select low while the block is idle is taken as the address cycle. On that edge the block latches the address from the data lines and raises a local address strobe of its own. Every later cycle with chip-select still low carries one data beat. The block turns each data beat into a clean local address, a one-cycle read or write strobe, and the write data, which drive a plain memory or register array.

Bit 21 of the word sent in the address cycle selects the access type. When it is 0 the access is a single beat. When it is 1 the access is a burst of four beats. The host sends only one address for a burst, so the block works out the address of each later beat itself, one word (4 bytes) at a time. If chip-select is released before the access is complete, the sequence is dropped and the block waits for the next address cycle.

Top module: `mbslv_tracker`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `loc_as`, `loc_rd` and `loc_wr` are 0, `loc_addr` is 0 and `loc_wdata` is 0.
- R2: A rising clock edge that samples `bus_cs_n` low while the block is idle is the address cycle. On it, `bus_ad[20:0]` is latched as the base address and `bus_wr` is latched as the direction (1 means write). `loc_as` is 1 for exactly the one cycle after that edge.
- R3: If `bus_ad[21]` is 1 in the address cycle, the access has four data beats. If it is 0, the access has one data beat.
- R4: Each edge after the address cycle that samples `bus_cs_n` low, within the beat count, is a data beat. In the cycle after that edge, exactly one of `loc_wr` (write access) or `loc_rd` (read access) is 1, `loc_addr` holds the beat address, and `loc_wdata` holds `bus_ad` as sampled on that edge.
- R5: The burst beat addresses are base, base+4, base+8 and base+12, computed modulo 2^21.
- R6: A single access accepts exactly one data beat. Further cycles with `bus_cs_n` low raise no strobe until `bus_cs_n` has been sampled high.
- R7: After the fourth beat of a burst, further cycles with `bus_cs_n` low raise no strobe until `bus_cs_n` has been sampled high.
- R8: If `bus_cs_n` is sampled high in the middle of an access, the access is aborted and the beat count is cleared. The next edge that samples `bus_cs_n` low is a new address cycle.
- R9: `loc_rd` and `loc_wr` are never 1 together, and neither is 1 in the same cycle as `loc_as`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Bank chip-select from the host, active low |
| bus_wr | input | 1 | Direction of the access, sampled in the address cycle (1 means write) |
| bus_ad | input | 32 | Multiplexed lines: the address in the address cycle, the data in the data beats |
| loc_as | output | 1 | Local address strobe, one cycle long |
| loc_addr | output | 21 | Local byte address of the current beat |
| loc_rd | output | 1 | Read strobe for one beat |
| loc_wr | output | 1 | Write strobe for one beat |
| loc_wdata | output | 32 | Write data of the current beat |

## Verification
Every output is a register, so each result is due in the cycle after the rising edge that samples its stimulus. `loc_as` follows the address cycle by one cycle, and each beat strobe follows the beat edge by one cycle. The bench changes its inputs on the falling edge and checks the outputs at the next falling edge. In that way each check falls exactly one registered stage after the stimulus it belongs to. The vector table sets out that cycle-by-cycle timing for single accesses, bursts, extra beats and aborts. Directed tests then cover address wrap-around and a reset in the middle of a burst.

// File: rtl/mbslv_pkg.sv
package mbslv_pkg;

    localparam int ADDR_W     = 21;
    localparam int DATA_W     = 32;
    localparam int FLAG_BIT   = 21;
    localparam int BURST_LEN  = 4;
    localparam int WORD_BYTES = 4;
    localparam int BEAT_W     = $clog2(BURST_LEN);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              burst;
        logic              write;
    } cmd_t;

    function automatic logic [BEAT_W-1:0] last_beat(input logic burst);
        return burst ? BEAT_W'(BURST_LEN - 1) : '0;
    endfunction

    function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] base,
                                                    input logic [BEAT_W-1:0] idx);
        return base + ADDR_W'(idx) * ADDR_W'(WORD_BYTES);
    endfunction

endpackage

// File: rtl/mbslv_phase_fsm.sv
module mbslv_phase_fsm
    import mbslv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              cmd_burst,
    output logic              addr_phase,
    output logic              beat_fire,
    output logic [BEAT_W-1:0] beat_idx
);

    phase_e            state;
    logic [BEAT_W-1:0] beat_q;

    assign addr_phase = (state == PH_IDLE) && !cs_n;
    assign beat_fire  = (state == PH_DATA) && !cs_n;
    assign beat_idx   = beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PH_IDLE;
            beat_q <= '0;
        end else if (cs_n) begin
            state  <= PH_IDLE;
            beat_q <= '0;
        end else begin
            unique case (state)
                PH_IDLE: begin
                    state  <= PH_DATA;
                    beat_q <= '0;
                end
                PH_DATA: begin
                    if (beat_q == last_beat(cmd_burst)) begin
                        state  <= PH_DONE;
                        beat_q <= '0;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                    end
                end
                default: state <= PH_DONE;
            endcase
        end
    end

    // R8
    abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n && state != PH_IDLE) |=> (state == PH_IDLE && beat_q == '0));

    // R6
    single_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_fire && !cmd_burst) |=> (state != PH_DATA));

    // R7
    burst_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_DONE) |-> (beat_q == '0));

endmodule

// File: rtl/mbslv_addr_cap.sv
module mbslv_addr_cap
    import mbslv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_phase,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_ad,
    output cmd_t              cmd,
    output logic              as_strobe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd       <= '0;
            as_strobe <= 1'b0;
        end else begin
            as_strobe <= addr_phase;
            if (addr_phase) begin
                cmd.base  <= bus_ad[ADDR_W-1:0];
                cmd.burst <= bus_ad[FLAG_BIT];
                cmd.write <= bus_wr;
            end
        end
    end

    // R2
    as_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        as_strobe |=> !as_strobe);

endmodule

// File: rtl/mbslv_beat_out.sv
module mbslv_beat_out
    import mbslv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_fire,
    input  logic [BEAT_W-1:0] beat_idx,
    input  cmd_t              cmd,
    input  logic [DATA_W-1:0] bus_ad,
    output logic [ADDR_W-1:0] loc_addr,
    output logic              loc_rd,
    output logic              loc_wr,
    output logic [DATA_W-1:0] loc_wdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_addr  <= '0;
            loc_rd    <= 1'b0;
            loc_wr    <= 1'b0;
            loc_wdata <= '0;
        end else begin
            loc_rd <= beat_fire && !cmd.write;
            loc_wr <= beat_fire &&  cmd.write;
            if (beat_fire) begin
                loc_addr  <= beat_addr(cmd.base, beat_idx);
                loc_wdata <= bus_ad;
            end
        end
    end

    // R9
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(loc_rd && loc_wr));

    // R5
    burst_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((loc_rd || loc_wr) && $past(loc_rd || loc_wr))
            |-> (loc_addr == $past(loc_addr) + ADDR_W'(WORD_BYTES)));

endmodule

// File: rtl/mbslv_tracker.sv
module mbslv_tracker
    import mbslv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs_n,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_ad,
    output logic              loc_as,
    output logic [ADDR_W-1:0] loc_addr,
    output logic              loc_rd,
    output logic              loc_wr,
    output logic [DATA_W-1:0] loc_wdata
);

    logic              addr_phase;
    logic              beat_fire;
    logic [BEAT_W-1:0] beat_idx;
    cmd_t              cmd;

    mbslv_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (bus_cs_n),
        .cmd_burst  (cmd.burst),
        .addr_phase (addr_phase),
        .beat_fire  (beat_fire),
        .beat_idx   (beat_idx)
    );

    mbslv_addr_cap u_cap (
        .clk       (clk),
        .rst       (rst),
        .addr_phase(addr_phase),
        .bus_wr    (bus_wr),
        .bus_ad    (bus_ad),
        .cmd       (cmd),
        .as_strobe (loc_as)
    );

    mbslv_beat_out u_out (
        .clk       (clk),
        .rst       (rst),
        .beat_fire (beat_fire),
        .beat_idx  (beat_idx),
        .cmd       (cmd),
        .bus_ad    (bus_ad),
        .loc_addr  (loc_addr),
        .loc_rd    (loc_rd),
        .loc_wr    (loc_wr),
        .loc_wdata (loc_wdata)
    );

    // R9
    as_vs_beat_chk: assert property (@(posedge clk) disable iff (rst)
        !(loc_as && (loc_rd || loc_wr)));

endmodule

// File: tb/mbslv_tracker_bench.sv
module mbslv_tracker_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cs_n = 1'b1;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_ad = '0;
    logic        loc_as;
    logic [20:0] loc_addr;
    logic        loc_rd;
    logic        loc_wr;
    logic [31:0] loc_wdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mbslv_tracker u_mbslv_tracker (
        .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_wr(bus_wr), .bus_ad(bus_ad),
        .loc_as(loc_as), .loc_addr(loc_addr), .loc_rd(loc_rd), .loc_wr(loc_wr),
        .loc_wdata(loc_wdata)
    );

    typedef struct packed {
        logic        cs_n;
        logic        wr;
        logic [31:0] ad;
        logic        e_as;
        logic        e_rd;
        logic        e_wr;
        logic [20:0] e_addr;
        logic [31:0] e_wd;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 21'h0,      32'h0},          // idle
        '{1'b0, 1'b1, 32'h0000_0100, 1'b1, 1'b0, 1'b0, 21'h0,      32'h0},          // R2 single write addr
        '{1'b0, 1'b1, 32'hAAAA_0001, 1'b0, 1'b0, 1'b1, 21'h100,    32'hAAAA_0001},  // R4
        '{1'b0, 1'b1, 32'h5555_0002, 1'b0, 1'b0, 1'b0, 21'h0,      32'h0},          // R6 extra beat
        '{1'b0, 1'b1, 32'h5555_0003, 1'b0, 1'b0, 1'b0, 21'h0,      32'h0},          // R6 extra beat
        '{1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 21'h0,      32'h0},
        '{1'b0, 1'b0, 32'h0020_0040, 1'b1, 1'b0, 1'b0, 21'h0,      32'h0},          // R3 burst read
        '{1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 21'h40,     32'h0},          // R5
        '{1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 21'h44,     32'h0},
        '{1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 21'h48,     32'h0},
        '{1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 21'h4C,     32'h0},
        '{1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 21'h0,      32'h0},          // R7 fifth cycle
        '{1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 21'h0,      32'h0},
        '{1'b0, 1'b1, 32'h0020_1000, 1'b1, 1'b0, 1'b0, 21'h0,      32'h0},          // burst write
        '{1'b0, 1'b1, 32'h0000_0011, 1'b0, 1'b0, 1'b1, 21'h1000,   32'h0000_0011},
        '{1'b0, 1'b1, 32'h0000_0022, 1'b0, 1'b0, 1'b1, 21'h1004,   32'h0000_0022},
        '{1'b1, 1'b1, 32'h0000_0033, 1'b0, 1'b0, 1'b0, 21'h0,      32'h0},          // R8 abort
        '{1'b0, 1'b1, 32'h0020_2000, 1'b1, 1'b0, 1'b0, 21'h0,      32'h0},          // R8 new addr cycle
        '{1'b0, 1'b1, 32'h0000_0044, 1'b0, 1'b0, 1'b1, 21'h2000,   32'h0000_0044},  // R8 count cleared
        '{1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 21'h0,      32'h0},
        '{1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 21'h0,      32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic cs_n, input logic wr, input logic [31:0] ad);
        bus_cs_n = cs_n;
        bus_wr   = wr;
        bus_ad   = ad;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs held at zero during reset
        chk("R1 as", {31'b0, loc_as}, 32'h0);
        chk("R1 rd/wr", {30'b0, loc_rd, loc_wr}, 32'h0);
        chk("R1 addr", {11'b0, loc_addr}, 32'h0);
        chk("R1 wdata", loc_wdata, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {29'b0, loc_as, loc_rd, loc_wr}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].cs_n, VEC[i].wr, VEC[i].ad);
            chk($sformatf("R2 as v%0d", i), {31'b0, loc_as}, {31'b0, VEC[i].e_as});
            chk($sformatf("R4 rd v%0d", i), {31'b0, loc_rd}, {31'b0, VEC[i].e_rd});
            chk($sformatf("R4 wr v%0d", i), {31'b0, loc_wr}, {31'b0, VEC[i].e_wr});
            if (VEC[i].e_rd || VEC[i].e_wr) begin
                chk($sformatf("R5 addr v%0d", i), {11'b0, loc_addr}, {11'b0, VEC[i].e_addr});
                if (VEC[i].e_wr)
                    chk($sformatf("R4 wdata v%0d", i), loc_wdata, VEC[i].e_wd);
            end
        end

        // R5 wrap modulo 2^21 in a burst read
        drive(1'b0, 1'b0, 32'h003F_FFFC);
        chk("R3 wrap as", {31'b0, loc_as}, 32'h1);
        drive(1'b0, 1'b0, 32'h0);
        chk("R5 wrap beat0", {11'b0, loc_addr}, 32'h001F_FFFC);
        chk("R9 beat0 rd only", {30'b0, loc_rd, loc_wr}, 32'h2);
        drive(1'b0, 1'b0, 32'h0);
        chk("R5 wrap beat1", {11'b0, loc_addr}, 32'h0000_0000);
        drive(1'b0, 1'b0, 32'h0);
        chk("R5 wrap beat2", {11'b0, loc_addr}, 32'h0000_0004);
        drive(1'b0, 1'b0, 32'h0);
        chk("R5 wrap beat3", {11'b0, loc_addr}, 32'h0000_0008);
        drive(1'b0, 1'b0, 32'h0);
        chk("R7 after last", {29'b0, loc_as, loc_rd, loc_wr}, 32'h0);
        drive(1'b1, 1'b0, 32'h0);

        // R1 reset in the middle of a burst, chip-select kept low
        drive(1'b0, 1'b1, 32'h0020_0300);
        drive(1'b0, 1'b1, 32'h0000_0077);
        chk("R4 pre-reset wr", {31'b0, loc_wr}, 32'h1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-burst reset", {29'b0, loc_as, loc_rd, loc_wr}, 32'h0);
        chk("R1 mid-burst addr", {11'b0, loc_addr}, 32'h0);
        rst = 1'b0;
        drive(1'b0, 1'b1, 32'h0000_0500);
        chk("R2 addr cycle after reset", {31'b0, loc_as}, 32'h1);
        drive(1'b0, 1'b1, 32'h0000_0088);
        chk("R3 single after reset", {11'b0, loc_addr}, 32'h0000_0500);
        chk("R4 single wdata", loc_wdata, 32'h0000_0088);
        drive(1'b0, 1'b1, 32'h0000_0099);
        chk("R6 no second beat", {31'b0, loc_wr}, 32'h0);
        drive(1'b1, 1'b0, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule